// File: doc/BRIEF.md
# Audio Serial Clock and Frame Generator

This block drives the clock side and data side of a three-wire audio serial output. A source clock is chosen: either every cycle of the system clock or an external tick strobe. An 8-bit count divides that source down to a bit clock. A 6-bit count then divides the bit clock to make the word-select line, which marks the left half-frame (low) and the right half-frame (high). Serial data is framed against word select in one of three justifications. In the default framing the most significant bit follows the word-select edge by one bit clock. The other two framings put the MSB on the edge, or put the LSB in the last slot of the half-frame.

A parallel sample port feeds the shifter. At every frame start, which is the word-select falling edge, the block raises a one-cycle ready strobe and takes a left/right pair if one is valid. If none is valid it sends silence for that frame and latches an underrun flag. A mono mode repeats the left sample in the right half-frame. A trigger output, gated by its own enable, pulses for one cycle on every word-select rising edge to start an external converter. A single enable runs both counters; dropping it stops and zeroes them.

Top module: `audio_frame_clkgen`

## Requirements
- R1: With bit-clock divide value N (0 treated as 1), bclk_o is high for N source ticks and low for N source ticks, so its period is 2N source ticks.
- R2: With word-select divide value L (0 treated as 1), ws_o holds each level for exactly L bit-clock periods, and it changes only together with a bclk_o falling edge.
- R3: While en_i is 0, bclk_o, ws_o, sd_o, trig_o and underrun_o are 0 and both counts are zero. After en_i rises, the first bclk_o rising edge comes N source ticks later.
- R4: With src_sel_i = 1 the divider counts only cycles in which ext_tick_i is 1. With src_sel_i = 0 it counts every clock cycle.
- R5: fmt_i = 2'b00 (standard): the sample MSB is sent in the second bit slot after each word-select edge, followed by the remaining W-1 bits. W is the sample width, min(width_i, L, DATA_W). All other slots are 0.
- R6: fmt_i = 2'b01 (left-justified): the sample MSB is sent in the first bit slot after each word-select edge, followed by the remaining bits. Trailing slots are 0. Code 2'b11 behaves as 2'b00.
- R7: fmt_i = 2'b10 (right-justified): the sample LSB is sent in the last bit slot of the half-frame. Leading slots are 0.
- R8: With mono_i = 1 the right half-frame carries the accepted left sample, and samp_right_i is ignored.
- R9: trig_o is high for one cycle on the cycle in which ws_o first reads 1, and only if trig_en_i was 1. With trig_en_i = 0 it stays 0.
- R10: samp_ready_o is high for exactly the one cycle before each ws_o falling edge. A pair is taken from samp_left_i/samp_right_i in that cycle when samp_valid_i is 1.
- R11: If samp_valid_i is 0 in a ready cycle, that frame is sent as all zeros and underrun_o becomes 1. It stays 1 until en_i is cleared.
- R12: sd_o changes only in the cycle where bclk_o falls, so it is stable at every bclk_o rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Runs both counts; 0 stops and zeroes them |
| src_sel_i | input | 1 | 0: count every cycle; 1: count ext_tick_i |
| ext_tick_i | input | 1 | External source tick strobe |
| bclk_div_i | input | 8 | Bit-clock half-period in source ticks |
| ws_div_i | input | 6 | Half-frame length in bit clocks |
| width_i | input | 6 | Sample width in bits |
| fmt_i | input | 2 | Framing: 00 standard, 01 left-justified, 10 right-justified |
| mono_i | input | 1 | Repeat the left sample in the right half |
| trig_en_i | input | 1 | Enables the converter trigger pulse |
| samp_valid_i | input | 1 | A sample pair is offered |
| samp_left_i | input | 32 | Left sample, right-aligned |
| samp_right_i | input | 32 | Right sample, right-aligned |
| samp_ready_o | output | 1 | Pair accepted this cycle when valid |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select, 0 = left |
| sd_o | output | 1 | Serial data |
| trig_o | output | 1 | Converter trigger pulse |
| underrun_o | output | 1 | Sticky missing-sample flag |

## Verification
The bench aims at the slot-zero case of the standard framing with a full-width sample. There the last bit of the previous right sample lands in the first slot of the next frame, and a design that reloaded its pair too early would send the new sample's bit in that slot. It also runs a divide value of zero, an external tick source and a restart from enable. A divider that counted one tick too many or too few would show up as a wrong bit-clock period or first-edge latency. Mono mode is driven with a distinct right sample so that a leak of samp_right_i is visible. The trigger enable is checked both ways, and a missing sample is checked for the zero frame and for the sticky flag that clears only on disable.

// File: rtl/audio_frame_clkgen_pkg.sv
// Shared encodings for the audio serial clock and frame generator.
package audio_frame_clkgen_pkg;
    // Framing of serial data relative to word select; code 2'b11 acts as standard.
    typedef enum logic [1:0] {
        FMT_STD   = 2'b00,
        FMT_LEFT  = 2'b01,
        FMT_RIGHT = 2'b10
    } frame_fmt_e;
endpackage

// File: rtl/afc_bclk_div.sv
// Bit-clock divider. Counts source ticks; each time the count reaches the
// divide value (0 read as 1) the bit clock toggles and the count restarts.
// Assumes: the divide value is changed only while disabled.
module afc_bclk_div #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic [CW-1:0] div_i,
    output logic          bclk_o,
    output logic          fall_evt_o
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          hit;

    // Effective divide value and terminal-count detect.
    always_comb begin
        lim = (div_i == '0) ? CW'(1) : div_i;
        hit = tick_i && (cnt >= lim - 1'b1);
    end

    // A falling edge is the toggle taken while the bit clock is high.
    assign fall_evt_o = en_i && hit && bclk_o;

    // Tick counter and bit-clock flop; cleared whenever disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt    <= '0;
            bclk_o <= 1'b0;
        end else if (tick_i) begin
            if (hit) begin
                cnt    <= '0;
                bclk_o <= ~bclk_o;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!bclk_o && cnt == '0))
        else $error("bit clock not idle after disable");

    assert_toggle_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && bclk_o != $past(bclk_o)) |-> $past(tick_i))
        else $error("bit clock toggled without a source tick");
endmodule

// File: rtl/afc_ws_count.sv
// Word-select counter. Counts bit-clock periods at each falling edge and
// flips word select after the programmed half-frame length (0 read as 1).
// Also raises the frame-start strobe and the gated converter trigger.
// Assumes: the divide value is changed only while disabled.
module afc_ws_count #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          fall_evt_i,
    input  logic [CW-1:0] ws_div_i,
    input  logic          trig_en_i,
    output logic          ws_o,
    output logic [CW-1:0] half_len_o,
    output logic [CW-1:0] pos_next_o,
    output logic          ws_next_o,
    output logic          frame_start_o,
    output logic          trig_o
);
    logic [CW-1:0] bitcnt;
    logic          wrap;

    // Slot position and word-select level that the next falling edge produces.
    always_comb begin
        half_len_o    = (ws_div_i == '0) ? CW'(1) : ws_div_i;
        wrap          = bitcnt >= half_len_o - 1'b1;
        pos_next_o    = wrap ? '0 : bitcnt + 1'b1;
        ws_next_o     = wrap ? ~ws_o : ws_o;
        frame_start_o = fall_evt_i && wrap && ws_o;
    end

    // Bit counter, word-select flop and trigger pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            bitcnt <= '0;
            ws_o   <= 1'b0;
            trig_o <= 1'b0;
        end else begin
            trig_o <= trig_en_i && fall_evt_i && wrap && !ws_o;
            if (fall_evt_i) begin
                bitcnt <= pos_next_o;
                ws_o   <= ws_next_o;
            end
        end
    end

    assert_ws_moves_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && ws_o != $past(ws_o)) |-> $past(fall_evt_i))
        else $error("word select moved off a bit-clock fall");

    assert_trig_on_ws_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (ws_o && !$past(ws_o) && $past(trig_en_i)))
        else $error("trigger without a gated word-select rise");
endmodule

// File: rtl/afc_shifter.sv
// Serial data shifter. On each bit-clock falling edge it picks the bit for
// the new slot from the held pair according to the framing. At frame start
// it loads the offered pair, or zeros plus a sticky underrun.
// Assumes: sample data is right-aligned in DW bits.
module afc_shifter
    import audio_frame_clkgen_pkg::*;
#(
    parameter int DW = 32,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          shift_evt_i,
    input  logic          frame_start_i,
    input  logic [PW-1:0] pos_i,
    input  logic          ws_next_i,
    input  logic [PW-1:0] half_len_i,
    input  logic [PW-1:0] width_i,
    input  logic [1:0]    fmt_i,
    input  logic          mono_i,
    input  logic          valid_i,
    input  logic [DW-1:0] left_i,
    input  logic [DW-1:0] right_i,
    output logic          sd_o,
    output logic          underrun_o
);
    localparam int QW = PW + 1;
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    logic [DW-1:0] hold_l, hold_r, new_l, new_r, src;
    logic [QW-1:0] hl, q, qi, pp, wd, tail, idx;
    logic          ch_r, bit_on, bit_val;

    // Slot arithmetic: frame slot, framing shift, channel and data bit pick.
    always_comb begin
        hl    = {1'b0, half_len_i};
        q     = ws_next_i ? hl + {1'b0, pos_i} : {1'b0, pos_i};
        qi    = q;
        if (fmt_i != FMT_LEFT && fmt_i != FMT_RIGHT)
            qi = (q == '0) ? {hl[QW-2:0], 1'b0} - 1'b1 : q - 1'b1;
        ch_r  = qi >= hl;
        pp    = ch_r ? qi - hl : qi;
        wd    = (width_i == '0) ? QW'(1) : {1'b0, width_i};
        if (wd > hl) wd = hl;
        if (wd > QW'(DW)) wd = QW'(DW);
        tail  = hl - 1'b1 - pp;
        if (fmt_i == FMT_RIGHT) begin
            bit_on = tail < wd;
            idx    = tail;
        end else begin
            bit_on = pp < wd;
            idx    = wd - 1'b1 - pp;
        end
        new_l   = valid_i ? left_i : '0;
        new_r   = valid_i ? (mono_i ? left_i : right_i) : '0;
        src     = ch_r ? hold_r : (frame_start_i ? new_l : hold_l);
        bit_val = bit_on && src[idx[IW-1:0]];
    end

    // Output bit, held pair and sticky underrun; all cleared when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            sd_o       <= 1'b0;
            hold_l     <= '0;
            hold_r     <= '0;
            underrun_o <= 1'b0;
        end else begin
            if (shift_evt_i) sd_o <= bit_val;
            if (frame_start_i) begin
                hold_l <= new_l;
                hold_r <= new_r;
                if (!valid_i) underrun_o <= 1'b1;
            end
        end
    end

    assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(underrun_o) && $past(en_i)) |-> underrun_o)
        else $error("underrun flag dropped while enabled");

    assert_underrun_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_o && !$past(underrun_o)) |-> ($past(frame_start_i) && !$past(valid_i)))
        else $error("underrun set without a missed sample");
endmodule

// File: rtl/audio_frame_clkgen.sv
// Top of the audio serial clock and frame generator: source-tick select,
// bit-clock divider, word-select counter and data shifter.
// Assumes: configuration inputs change only while en_i is 0.
module audio_frame_clkgen
    import audio_frame_clkgen_pkg::*;
#(
    parameter int BCLK_W = 8,
    parameter int WS_W   = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              src_sel_i,
    input  logic              ext_tick_i,
    input  logic [BCLK_W-1:0] bclk_div_i,
    input  logic [WS_W-1:0]   ws_div_i,
    input  logic [WS_W-1:0]   width_i,
    input  logic [1:0]        fmt_i,
    input  logic              mono_i,
    input  logic              trig_en_i,
    input  logic              samp_valid_i,
    input  logic [DATA_W-1:0] samp_left_i,
    input  logic [DATA_W-1:0] samp_right_i,
    output logic              samp_ready_o,
    output logic              bclk_o,
    output logic              ws_o,
    output logic              sd_o,
    output logic              trig_o,
    output logic              underrun_o
);
    logic            tick, fall_evt, ws_next, frame_start;
    logic [WS_W-1:0] half_len, pos_next;

    // Source tick: every cycle, or the external strobe.
    assign tick         = src_sel_i ? ext_tick_i : 1'b1;
    assign samp_ready_o = frame_start;

    afc_bclk_div #(.CW(BCLK_W)) u_bclk (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick),
        .div_i(bclk_div_i), .bclk_o(bclk_o), .fall_evt_o(fall_evt)
    );

    afc_ws_count #(.CW(WS_W)) u_ws (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .fall_evt_i(fall_evt),
        .ws_div_i(ws_div_i), .trig_en_i(trig_en_i), .ws_o(ws_o),
        .half_len_o(half_len), .pos_next_o(pos_next), .ws_next_o(ws_next),
        .frame_start_o(frame_start), .trig_o(trig_o)
    );

    afc_shifter #(.DW(DATA_W), .PW(WS_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .shift_evt_i(fall_evt),
        .frame_start_i(frame_start), .pos_i(pos_next), .ws_next_i(ws_next),
        .half_len_i(half_len), .width_i(width_i), .fmt_i(fmt_i),
        .mono_i(mono_i), .valid_i(samp_valid_i), .left_i(samp_left_i),
        .right_i(samp_right_i), .sd_o(sd_o), .underrun_o(underrun_o)
    );

    assert_sd_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && sd_o != $past(sd_o)) |-> ($past(bclk_o) && !bclk_o))
        else $error("serial data moved off a bit-clock fall");

    assert_ready_before_ws_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        samp_ready_o |=> (!ws_o && $past(ws_o)))
        else $error("ready not followed by a word-select fall");
endmodule

// File: tb/audio_frame_clkgen_bench.sv
module audio_frame_clkgen_bench;
    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, src_sel = 1'b0, ext_tick = 1'b0;
    logic [7:0] bdiv = 8'd2;
    logic [5:0] wdiv = 6'd8, width = 6'd8;
    logic [1:0] fmt = 2'b00;
    logic mono = 1'b0, trig_en = 1'b0, valid = 1'b0;
    logic [31:0] sl = '0, sr = '0;
    logic ready, bclk, ws, sd, trig, und;

    int n_chk = 0, n_fail = 0, tk_cnt = 0;
    logic ws_a [0:511];
    logic sd_a [0:511];
    int   st_a [0:511];
    int   ncap, bad_sd, bad_rdy, bad_trig, n_trig;

    always #2 clk = ~clk;

    audio_frame_clkgen u_audio_frame_clkgen (
        .clk(clk), .rst_n(rst_n), .en_i(en), .src_sel_i(src_sel),
        .ext_tick_i(ext_tick), .bclk_div_i(bdiv), .ws_div_i(wdiv),
        .width_i(width), .fmt_i(fmt), .mono_i(mono), .trig_en_i(trig_en),
        .samp_valid_i(valid), .samp_left_i(sl), .samp_right_i(sr),
        .samp_ready_o(ready), .bclk_o(bclk), .ws_o(ws), .sd_o(sd),
        .trig_o(trig), .underrun_o(und)
    );

    // External tick: one cycle in three.
    initial forever begin
        @(negedge clk);
        tk_cnt++;
        ext_tick = (tk_cnt % 3 == 0);
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_frame(int f, int L, int W, logic [31:0] l, logic [31:0] r, bit m);
        logic [127:0] e = '0;
        for (int q = 0; q < 2 * L; q++) begin
            int qi = (f == 1 || f == 2) ? q : (q + 2 * L - 1) % (2 * L);
            int p = qi % L;
            logic [31:0] s = (qi >= L) ? (m ? l : r) : l;
            if (f == 2) e[q] = (L - 1 - p < W) ? s[L - 1 - p] : 1'b0;
            else        e[q] = (p < W) ? s[W - 1 - p] : 1'b0;
        end
        return e;
    endfunction

    // Disable, load a configuration, then enable at a falling clock edge.
    task automatic start(int f, int nd, int ld, int w, bit m, bit sel, bit te, bit v,
                         logic [31:0] l, logic [31:0] r);
        en = 1'b0;
        repeat (3) @(negedge clk);
        fmt = 2'(f); bdiv = 8'(nd); wdiv = 6'(ld); width = 6'(w); mono = m;
        src_sel = sel; trig_en = te; valid = v; sl = l; sr = r;
        en = 1'b1;
    endtask

    // Record ws and sd at each bclk rise, and watch edge relations per cycle.
    task automatic capture(int n);
        logic pb = bclk, pws = ws, psd = sd, pend = 1'b0;
        int cyc = 0;
        ncap = 0; bad_sd = 0; bad_rdy = 0; bad_trig = 0; n_trig = 0;
        while (ncap < n && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (!pb && bclk) begin
                ws_a[ncap] = ws; sd_a[ncap] = sd; st_a[ncap] = cyc; ncap++;
            end
            if (sd != psd && !(pb && !bclk)) bad_sd++;
            if (pend != (pws && !ws)) bad_rdy++;
            if (trig != (trig_en && ws && !pws)) bad_trig++;
            if (trig) n_trig++;
            pend = ready; pb = bclk; pws = ws; psd = sd;
        end
    endtask

    // Compare the frame starting at the second ws fall with the model.
    task automatic frame_chk(string req, int f, int L, int W, logic [31:0] l, logic [31:0] r, bit m);
        int seen = 0, at = -1;
        logic [127:0] act = '0, exp;
        for (int i = 1; i < ncap; i++)
            if (ws_a[i-1] && !ws_a[i]) begin
                seen++;
                if (seen == 2) at = i;
            end
        exp = exp_frame(f, L, W, l, r, m);
        if (at < 0 || at + 2 * L > ncap) begin
            chk(1'b0, req, 128'(ncap), 128'(2 * L));
            return;
        end
        for (int q = 0; q < 2 * L; q++) act[q] = sd_a[at + q];
        chk(act == exp, req, act, exp);
    endtask

    task automatic period_chk(string req, int per);
        int bad = 0;
        for (int i = 2; i < ncap; i++) if (st_a[i] - st_a[i-1] != per) bad++;
        chk(bad == 0 && ncap > 3, req, 128'(bad), 128'(0));
    endtask

    task automatic ws_period_chk(string req, int L);
        int last = -1, bad = 0, nf = 0;
        for (int i = 1; i < ncap; i++)
            if (ws_a[i-1] != ws_a[i]) begin
                if (last >= 0 && i - last != L) bad++;
                last = i; nf++;
            end
        chk(bad == 0 && nf > 2, "R2 ws half-period", 128'(bad), 128'(0));
        if (req.len() == 0) return;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(!bclk && !ws && !sd && !trig && !und && !ready, "R3 reset idle",
            {bclk, ws, sd, trig, und, ready}, 0);
    endtask

    task automatic t_std();
        start(0, 2, 8, 8, 0, 0, 0, 1, 32'hA5, 32'h3C);
        capture(60);
        frame_chk("R5 standard full-width frame", 0, 8, 8, 32'hA5, 32'h3C, 0);
        period_chk("R1 bclk period N=2", 4);
        ws_period_chk("R2", 8);
        chk(bad_rdy == 0, "R10 ready one cycle before ws fall", 128'(bad_rdy), 0);
        chk(bad_sd == 0, "R12 sd moves only on bclk fall", 128'(bad_sd), 0);
        chk(!und, "R11 no underrun when valid", und, 0);
    endtask

    task automatic t_left();
        start(1, 2, 10, 6, 0, 0, 0, 1, 32'h2D, 32'h13);
        capture(70);
        frame_chk("R6 left-justified frame", 1, 10, 6, 32'h2D, 32'h13, 0);
        start(3, 1, 10, 6, 0, 0, 0, 1, 32'h2D, 32'h13);
        capture(70);
        frame_chk("R6 code 11 acts as standard", 0, 10, 6, 32'h2D, 32'h13, 0);
    endtask

    task automatic t_right();
        start(2, 2, 10, 6, 0, 0, 0, 1, 32'h2D, 32'h13);
        capture(70);
        frame_chk("R7 right-justified frame", 2, 10, 6, 32'h2D, 32'h13, 0);
        chk(bad_sd == 0, "R12 sd stable at rises (right)", 128'(bad_sd), 0);
    endtask

    task automatic t_mono();
        start(1, 1, 8, 8, 1, 0, 0, 1, 32'hC6, 32'h5A);
        capture(60);
        frame_chk("R8 mono repeats left", 1, 8, 8, 32'hC6, 32'h5A, 1);
    endtask

    task automatic t_trig();
        start(0, 1, 4, 4, 0, 0, 1, 1, 32'h9, 32'h6);
        capture(40);
        chk(bad_trig == 0 && n_trig > 2, "R9 trigger on ws rise", 128'(n_trig), 128'(bad_trig));
        start(0, 1, 4, 4, 0, 0, 0, 1, 32'h9, 32'h6);
        capture(40);
        chk(n_trig == 0, "R9 trigger gated off", 128'(n_trig), 0);
    endtask

    task automatic t_ext();
        start(0, 2, 4, 4, 0, 1, 0, 1, 32'h9, 32'h6);
        capture(12);
        period_chk("R4 external tick source", 12);
    endtask

    task automatic t_div0();
        start(0, 0, 0, 1, 0, 0, 0, 1, 32'h1, 32'h0);
        capture(20);
        period_chk("R1 divide value 0 as 1", 2);
        frame_chk("R2 half-frame 0 as 1", 0, 1, 1, 32'h1, 32'h0, 0);
    endtask

    task automatic t_restart();
        int n = 0;
        start(1, 3, 4, 4, 0, 0, 0, 1, 32'h9, 32'h6);
        capture(10);
        en = 1'b0;
        @(negedge clk);
        chk(!bclk && !ws && !sd && !trig, "R3 disabled outputs low", {bclk, ws, sd, trig}, 0);
        en = 1'b1;
        while (!bclk && n < 50) begin @(negedge clk); n++; end
        chk(n == 3, "R3 first rise after enable", 128'(n), 128'(3));
    endtask

    task automatic t_underrun();
        start(1, 1, 6, 6, 0, 0, 0, 0, 32'h3F, 32'h3F);
        capture(40);
        frame_chk("R11 missing sample sends zeros", 1, 6, 6, 32'h0, 32'h0, 0);
        chk(und, "R11 underrun set", und, 1);
        valid = 1'b1;
        capture(20);
        chk(und, "R11 underrun stays set", und, 1);
        en = 1'b0;
        @(negedge clk);
        chk(!und, "R11 underrun cleared by disable", und, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_std();
        t_left();
        t_right();
        t_mono();
        t_trig();
        t_ext();
        t_div0();
        t_restart();
        t_underrun();
        summary();
        $finish;
    end
endmodule